// File: doc/BRIEF.md
# DMA Burst Threshold Calculator

This block chooses the burst length (packet size) a DMA engine should use for one audio stream, and the FIFO threshold that matches it. A start pulse loads the period length in words, the largest threshold the FIFO allows in the stream's direction, the channel count and a mode bit. The result comes back a number of cycles later, marked by a one-cycle done strobe, together with an error flag.

In threshold mode the block looks for the largest packet that divides the period evenly and still fits under the FIFO limit. It computes the rounded-up quotient of period over limit, then walks the divisor upward until it divides the period with no remainder. Each trial division runs on a serial restoring divider that yields one quotient bit per clock. If the walk reaches the period length itself, no usable packet exists and the error flag is raised. In plain mode a multichannel stream uses one frame per burst, a mono stream uses none, and the result is ready two cycles after start.

The start, mode, done, busy and error pins are plain control and status lines. The operands travel with start and the results travel with done, so there is no data stream and no valid/ready handshake; a caller that is not ready for a result simply waits, because the outputs hold until the next accepted start.

Top module: `burst_sizer`

## Requirements
- R1: After reset, busy_o, done_o and err_o are low, pkt_o is 0 and thresh_o is 1.
- R2: With thr_mode_i low and chans_i greater than 1, the result is pkt_o equal to chans_i with err_o low.
- R3: With thr_mode_i low and chans_i of 0 or 1, the result is pkt_o equal to 0 with err_o low.
- R4: With thr_mode_i high and either period_i or max_thr_i equal to 0, the result is err_o high and pkt_o equal to 0.
- R5: With thr_mode_i high and both operands nonzero, the divisor starts at period_i divided by max_thr_i rounded up and rises by one until it divides period_i evenly; if that divisor is below period_i, pkt_o is period_i divided by it and err_o is low.
- R6: If the search in R5 ends with the divisor equal to period_i, the result is err_o high and pkt_o equal to 0.
- R7: thresh_o is 0 when err_o is high, 1 when err_o is low and pkt_o is 0, and equal to pkt_o otherwise.
- R8: Every accepted start produces exactly one done_o pulse lasting one clock; busy_o is high from the cycle after an accepted start through the done cycle.
- R9: A start pulse while busy_o is high is ignored and does not change the result of the calculation in progress.
- R10: pkt_o, err_o and thresh_o hold their values from the done cycle until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a calculation (sampled when idle) |
| thr_mode_i | input | 1 | 1 = threshold-mode search, 0 = plain mode |
| period_i | input | W | Period length in words |
| max_thr_i | input | W | Largest FIFO threshold for the stream direction |
| chans_i | input | W | Channel count |
| busy_o | output | 1 | Calculation in progress |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | No valid packet size exists |
| pkt_o | output | W | Chosen packet size |
| thresh_o | output | W | FIFO threshold to program |

## Verification
The bench builds the block with W = 6, so the period can only range over 0 to 63 and the longest divisor walk stays near 60 trials of about eight cycles each. That makes it affordable to sweep every period against a dozen limits, including 0, 1, the prime-heavy small values and the maximum, which reaches the even split, the walk past non-divisors, the prime-period failure and the limit-of-one failure. All channel counts are swept in plain mode, and a mid-search start pulse plus an idle hold window exercise the ignore and hold rules.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_CEIL  = 3'd1,
    S_CHECK = 3'd2,
    S_MOD   = 3'd3,
    S_DONE  = 3'd4
  } bsz_state_e;
endpackage

// File: rtl/bsz_serdiv.sv
module bsz_serdiv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  dvs_q;
  logic [W-1:0]  dvd_q;
  logic [W:0]    part;
  logic [W:0]    diff;

  always_comb begin
    part = {rem, quot[W-1]};
    diff = part - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      quot  <= '0;
      rem   <= '0;
      dvs_q <= '0;
      dvd_q <= '0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        quot  <= dividend;
        rem   <= '0;
        dvs_q <= divisor;
        dvd_q <= dividend;
        cnt_q <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (!diff[W]) begin
          rem  <= diff[W-1:0];
          quot <= {quot[W-2:0], 1'b1};
        end else begin
          rem  <= part[W-1:0];
          quot <= {quot[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((2*W)'(quot) * (2*W)'(dvs_q) + (2*W)'(rem) == (2*W)'(dvd_q)) && (rem < dvs_q)); // R5
  AST_DIV_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R5
endmodule

// File: rtl/bsz_shape.sv
module bsz_shape #(
  parameter int W = 16
) (
  input  logic         err,
  input  logic [W-1:0] pkt,
  output logic [W-1:0] thresh
);
  always_comb begin
    if (err)             thresh = '0;
    else if (pkt == '0)  thresh = W'(1);
    else                 thresh = pkt;
  end
endmodule

// File: rtl/burst_sizer.sv
module burst_sizer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         thr_mode_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] max_thr_i,
  input  logic [W-1:0] chans_i,
  output logic         busy_o,
  output logic         done_o,
  output logic         err_o,
  output logic [W-1:0] pkt_o,
  output logic [W-1:0] thresh_o
);
  import bsz_pkg::*;

  bsz_state_e   state_q;
  logic [W-1:0] p_q, m_q, d_q, pkt_q;
  logic         err_q, mode_q;

  logic         div_go, div_busy, div_done;
  logic [W-1:0] div_dvd, div_dvs, div_q, div_r;

  always_comb begin
    div_go  = 1'b0;
    div_dvd = p_q;
    div_dvs = d_q;
    if (state_q == S_IDLE) begin
      div_dvd = period_i;
      div_dvs = max_thr_i;
      div_go  = start_i && thr_mode_i && (period_i != '0) && (max_thr_i != '0);
    end else if (state_q == S_CHECK) begin
      div_go  = (d_q != p_q);
    end
  end

  bsz_serdiv #(.W(W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy     (div_busy),
    .done     (div_done),
    .quot     (div_q),
    .rem      (div_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      p_q     <= '0;
      m_q     <= '0;
      d_q     <= '0;
      pkt_q   <= '0;
      err_q   <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          p_q    <= period_i;
          m_q    <= max_thr_i;
          mode_q <= thr_mode_i;
          if (!thr_mode_i) begin
            err_q   <= 1'b0;
            pkt_q   <= (chans_i > W'(1)) ? chans_i : '0;
            state_q <= S_DONE;
          end else if (period_i == '0 || max_thr_i == '0) begin
            err_q   <= 1'b1;
            pkt_q   <= '0;
            state_q <= S_DONE;
          end else begin
            err_q   <= 1'b0;
            pkt_q   <= '0;
            state_q <= S_CEIL;
          end
        end
        S_CEIL: if (div_done) begin
          d_q     <= div_q + W'(div_r != '0);
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (d_q == p_q) begin
            err_q   <= 1'b1;
            pkt_q   <= '0;
            state_q <= S_DONE;
          end else begin
            state_q <= S_MOD;
          end
        end
        S_MOD: if (div_done) begin
          if (div_r == '0) begin
            pkt_q   <= div_q;
            state_q <= S_DONE;
          end else begin
            d_q     <= d_q + W'(1);
            state_q <= S_CHECK;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  bsz_shape #(.W(W)) u_shape (
    .err    (err_q),
    .pkt    (pkt_q),
    .thresh (thresh_o)
  );

  assign busy_o = (state_q != S_IDLE);
  assign done_o = (state_q == S_DONE);
  assign err_o  = err_q;
  assign pkt_o  = pkt_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_ERR_ZERO_PKT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (pkt_o == '0) && (thresh_o == '0)); // R6
  AST_PKT_DIVIDES: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o && mode_q) |-> (pkt_o != '0) && (pkt_o <= m_q) &&
      ((p_q % ((pkt_o == '0) ? W'(1) : pkt_o)) == '0)); // R5
  AST_THR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> (thresh_o != '0)); // R7
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(p_q) && $stable(m_q) && $stable(mode_q)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(pkt_o) && $stable(err_o)); // R10
  AST_DIV_ONLY_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (state_q == S_CEIL || state_q == S_MOD)); // R5
endmodule

// File: tb/tb_burst_sizer.sv
module tb_burst_sizer;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         thr_mode_i = 1'b0;
  logic [W-1:0] period_i = '0;
  logic [W-1:0] max_thr_i = '0;
  logic [W-1:0] chans_i = '0;
  logic         busy_o, done_o, err_o;
  logic [W-1:0] pkt_o, thresh_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  burst_sizer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .thr_mode_i(thr_mode_i),
    .period_i(period_i), .max_thr_i(max_thr_i), .chans_i(chans_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .pkt_o(pkt_o), .thresh_o(thresh_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model(input bit mode, input int p, input int m,
                                input int c, output bit e, output int k);
    int d;
    e = 1'b0;
    k = 0;
    if (!mode) begin
      k = (c > 1) ? c : 0;
    end else if (p == 0 || m == 0) begin
      e = 1'b1;
    end else begin
      d = (p + m - 1) / m;
      while ((p % d) != 0 && d < p) d++;
      if (d == p) e = 1'b1;
      else k = p / d;
    end
  endfunction

  task automatic wait_done(input string req);
    int t = 0;
    while (!done_o && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk({req, " done seen"}, int'(done_o), 1);
  endtask

  task automatic run_one(input bit mode, input int p, input int m, input int c);
    bit e;
    int k;
    string req;
    model(mode, p, m, c, e, k);
    if (!mode) req = (c > 1) ? "R2" : "R3";
    else if (p == 0 || m == 0) req = "R4";
    else req = e ? "R6" : "R5";
    @(negedge clk);
    start_i    = 1'b1;
    thr_mode_i = mode;
    period_i   = W'(p);
    max_thr_i  = W'(m);
    chans_i    = W'(c);
    @(negedge clk);
    start_i = 1'b0;
    chk("R8 busy after start", int'(busy_o), 1);
    wait_done(req);
    chk({req, " err"}, int'(err_o), int'(e));
    chk({req, " pkt"}, int'(pkt_o), k);
    chk("R7 thresh", int'(thresh_o), e ? 0 : ((k == 0) ? 1 : k));
    @(negedge clk);
    chk("R8 single done", int'(done_o), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int mlist[12] = '{0, 1, 2, 3, 4, 5, 7, 8, 13, 16, 32, 63};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 pkt", int'(pkt_o), 0);
    chk("R1 thresh", int'(thresh_o), 1);

    // R2 / R3: plain mode over every channel count
    for (int c = 0; c < 64; c++) run_one(1'b0, (c * 3) % 64, c, c);

    // R4 / R5 / R6: threshold mode over all periods and a set of limits
    for (int mi = 0; mi < 12; mi++)
      for (int p = 0; p < 64; p++)
        run_one(1'b1, p, mlist[mi], p % 5);

    // R9: start while busy is ignored (60 words, limit 7 -> packet 6)
    @(negedge clk);
    start_i = 1'b1; thr_mode_i = 1'b1; period_i = W'(60); max_thr_i = W'(7); chans_i = W'(2);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start_i = 1'b1; thr_mode_i = 1'b0; chans_i = W'(5);
    @(negedge clk);
    start_i = 1'b0;
    wait_done("R9");
    chk("R9 pkt unaffected", int'(pkt_o), 6);
    chk("R9 err unaffected", int'(err_o), 0);
    @(negedge clk);
    chk("R9 no extra done", int'(done_o), 0);

    // R10: results hold while idle
    repeat (6) @(negedge clk);
    chk("R10 pkt hold", int'(pkt_o), 6);
    chk("R10 err hold", int'(err_o), 0);
    chk("R10 thresh hold", int'(thresh_o), 6);
    chk("R10 idle", int'(busy_o), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule